// File: doc/BRIEF.md
# Three-Weight Accumulator Test Pattern Generator

This block produces one test vector per clock for a circuit under test, built as a row of accumulator cells. Each cell is a full adder whose sum is captured in a pattern flop (register A). That flop's output loops back as one adder operand. A companion flop (register B) supplies the other operand, and a ripple carry joins the cells from bit 0 upward. Each pattern bit has one of three weights: constant 0, constant 1, or pseudorandom with probability one half. The random operand bits come from a 16-bit linear feedback shift register.

A forced bit drives its pattern flop to the constant and its B flop to the complement. A cell whose operands differ passes its carry-in straight to its carry-out. The carry from random bits below a forced bit therefore reaches random bits above it, and the adder needs no extra gating. The per-bit weights come from two mask inputs, one requesting constant 1 and one requesting constant 0. The masks are captured by a load strobe. When both are requested for a bit, the bit is driven to 0.

Top module: `tw_pattern_gen`

## Requirements
- R1: Synchronous active-high reset clears the pattern and B registers to 0, makes every bit random-weight, and loads the LFSR with its seed (default 16'hACE1).
- R2: A bit with only its one-request set reads 1 on every cycle while that mask is in force.
- R3: A bit with only its zero-request set reads 0 on every cycle while that mask is in force.
- R4: A bit with both requests set reads 0.
- R5: On each enabled clock, every random-weight bit of the pattern takes bit i of the full-width sum (pattern + B), with carry into bit 0 equal to 0. A new pattern appears every enabled clock.
- R6: A forced bit holds B at the complement of its pattern bit, so the carry passes through it unchanged. With every bit forced, no carry leaves the top cell.
- R7: The LFSR shifts left each enabled clock with new bit 0 = s[15]^s[13]^s[12]^s[10], and is never zero. On each enabled clock, B bit i of a random bit loads LFSR bit i (mod 16) as it stood before that clock.
- R8: With enable low and no load, the pattern, B and the LFSR hold.
- R9: A mask load is captured at the clock edge where the strobe is high. The newly forced bits show their constants right after that edge, with or without enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance accumulator and LFSR |
| mask_load | input | 1 | Capture new weight masks |
| one_req | input | WIDTH | Per-bit request for constant 1 |
| zero_req | input | WIDTH | Per-bit request for constant 0 (wins over one_req) |
| pattern | output | WIDTH | Registered test vector |

## Verification
The assertions check on every cycle that forced cells hold their constants with B complemented. They also check that an all-forced row yields no top carry, that the LFSR never reaches zero, that a load captures the masks, and that an idle cycle leaves the pattern unchanged. Only the bench's scenarios can show the arithmetic behaviour of the random bits against a reference sum, carry passing across forced gaps, the LFSR sequence, and the exact cycle at which a load takes effect. It drives these with directed mask layouts and seeded random enables and masks.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    W_RAND = 2'd0,
    W_ZERO = 2'd1,
    W_ONE  = 2'd2
  } weight_e;

  function automatic weight_e decode_weight(input logic one_r, input logic zero_r);
    if (zero_r)     return W_ZERO;
    else if (one_r) return W_ONE;
    else            return W_RAND;
  endfunction
endpackage

// File: rtl/tw_lfsr.sv
module tw_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst)     state <= SEED;
    else if (en) state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/tw_mask_ctl.sv
module tw_mask_ctl #(
  parameter int WIDTH = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [WIDTH-1:0]    one_in,
  input  logic [WIDTH-1:0]    zero_in,
  output logic [WIDTH-1:0]    one_q,
  output logic [WIDTH-1:0]    zero_q,
  output tw_pkg::weight_e     wt_d [WIDTH],
  output tw_pkg::weight_e     wt_q [WIDTH]
);
  logic [WIDTH-1:0] one_d, zero_d;

  assign one_d  = load ? one_in  : one_q;
  assign zero_d = load ? zero_in : zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      one_q  <= '0;
      zero_q <= '0;
    end else begin
      one_q  <= one_d;
      zero_q <= zero_d;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_dec
    assign wt_d[i] = tw_pkg::decode_weight(one_d[i], zero_d[i]);
    assign wt_q[i] = tw_pkg::decode_weight(one_q[i], zero_q[i]);
  end

  // R9
  mask_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (one_q == $past(one_in)) && (zero_q == $past(zero_in)));
endmodule

// File: rtl/tw_cell.sv
module tw_cell (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  tw_pkg::weight_e  wt_d,
  input  tw_pkg::weight_e  wt_q,
  input  logic             rnd_bit,
  input  logic             cin,
  output logic             a_q,
  output logic             cout
);
  logic b_q;
  logic sum;

  assign sum  = a_q ^ b_q ^ cin;
  assign cout = (a_q & b_q) | (cin & (a_q ^ b_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      case (wt_d)
        tw_pkg::W_ONE: begin
          a_q <= 1'b1;
          b_q <= 1'b0;
        end
        tw_pkg::W_ZERO: begin
          a_q <= 1'b0;
          b_q <= 1'b1;
        end
        default: begin
          if (en) begin
            a_q <= sum;
            b_q <= rnd_bit;
          end
        end
      endcase
    end
  end

  // R2
  forced_one_chk: assert property (@(posedge clk) disable iff (rst)
    (wt_q == tw_pkg::W_ONE) |-> (a_q && !b_q));

  // R3
  forced_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wt_q == tw_pkg::W_ZERO) |-> (!a_q && b_q));

  // R6
  carry_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (wt_q != tw_pkg::W_RAND) |-> (cout == cin));
endmodule

// File: rtl/tw_pattern_gen.sv
module tw_pattern_gen #(
  parameter int              WIDTH  = 10,
  parameter int              LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mask_load,
  input  logic [WIDTH-1:0] one_req,
  input  logic [WIDTH-1:0] zero_req,
  output logic [WIDTH-1:0] pattern
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [WIDTH-1:0]  one_q, zero_q;
  logic [WIDTH-1:0]  cout_v;
  logic [WIDTH-1:0]  cin_v;
  logic [WIDTH-1:0]  a_v;
  tw_pkg::weight_e   wt_d [WIDTH];
  tw_pkg::weight_e   wt_q [WIDTH];

  tw_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .state (lfsr_q)
  );

  tw_mask_ctl #(.WIDTH(WIDTH)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .load    (mask_load),
    .one_in  (one_req),
    .zero_in (zero_req),
    .one_q   (one_q),
    .zero_q  (zero_q),
    .wt_d    (wt_d),
    .wt_q    (wt_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    localparam int RIDX = i % LFSR_W;
    if (i == 0) begin : g_lsb
      assign cin_v[i] = 1'b0;
    end else begin : g_up
      assign cin_v[i] = cout_v[i-1];
    end
    tw_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .wt_d    (wt_d[i]),
      .wt_q    (wt_q[i]),
      .rnd_bit (lfsr_q[RIDX]),
      .cin     (cin_v[i]),
      .a_q     (a_v[i]),
      .cout    (cout_v[i])
    );
  end

  assign pattern = a_v;

  // R6
  all_forced_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (&(one_q | zero_q)) |-> !cout_v[WIDTH-1]);

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !mask_load) |=> $stable(pattern));
endmodule

// File: tb/tw_pattern_gen_test.sv
module tw_pattern_gen_test;
  localparam int W  = 10;
  localparam int LW = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         mask_load = 1'b0;
  logic [W-1:0] one_req = '0;
  logic [W-1:0] zero_req = '0;
  logic [W-1:0] pattern;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [W-1:0]  m_a, m_b, m_one, m_zero;
  logic [LW-1:0] m_lfsr;

  always #2 clk = ~clk;

  tw_pattern_gen uut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mask_load (mask_load),
    .one_req   (one_req),
    .zero_req  (zero_req),
    .pattern   (pattern)
  );

  function automatic logic [LW-1:0] lfsr_step(input logic [LW-1:0] s);
    return {s[LW-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pattern actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic e, input logic ld,
                      input logic [W-1:0] o, input logic [W-1:0] z);
    logic [W-1:0] od, zd, sum, na, nb;
    en = e; mask_load = ld; one_req = o; zero_req = z;
    od  = ld ? o : m_one;
    zd  = ld ? z : m_zero;
    sum = m_a + m_b;
    for (int i = 0; i < W; i++) begin
      if (zd[i])      begin na[i] = 1'b0; nb[i] = 1'b1; end
      else if (od[i]) begin na[i] = 1'b1; nb[i] = 1'b0; end
      else if (e)     begin na[i] = sum[i]; nb[i] = m_lfsr[i % LW]; end
      else            begin na[i] = m_a[i]; nb[i] = m_b[i]; end
    end
    @(posedge clk);
    m_a = na; m_b = nb; m_one = od; m_zero = zd;
    if (e) m_lfsr = lfsr_step(m_lfsr);
    @(negedge clk);
    check(req, pattern, m_a);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_a = '0; m_b = '0; m_one = '0; m_zero = '0; m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset", pattern, '0);
    // R1 R7 R5: free-running accumulation from seed, all random
    for (int k = 0; k < 24; k++) step("R5 R7 accumulate", 1'b1, 1'b0, '0, '0);
    // R9 R2: load with enable low, constants right after the load edge
    step("R9 load idle", 1'b0, 1'b1, 10'b1000100001, '0);
    check("R2 R9 ones visible", pattern & 10'b1000100001, 10'b1000100001);
    for (int k = 0; k < 12; k++) begin
      step("R2 forced one", 1'b1, 1'b0, 10'b1000100001, '0);
      check("R2 ones held", pattern & 10'b1000100001, 10'b1000100001);
    end
    // R3
    step("R3 load zeros", 1'b1, 1'b1, '0, 10'b0100010010);
    check("R3 R9 zeros visible", pattern & 10'b0100010010, '0);
    for (int k = 0; k < 12; k++) begin
      step("R3 forced zero", 1'b1, 1'b0, '0, 10'b0100010010);
      check("R3 zeros held", pattern & 10'b0100010010, '0);
    end
    // R4: both requested -> zero
    step("R4 both", 1'b1, 1'b1, 10'b0011000011, 10'b0010000001);
    check("R4 zero wins", pattern & 10'b0010000001, '0);
    check("R4 one kept", pattern & 10'b0001000010, 10'b0001000010);
    // R6: forced gap between random bits, carry must cross it
    step("R6 gap load", 1'b1, 1'b1, 10'b0000110000, 10'b0001001000);
    for (int k = 0; k < 30; k++) step("R6 carry across gap", 1'b1, 1'b0, 10'b0000110000, 10'b0001001000);
    // R6: all bits forced
    step("R6 all forced", 1'b1, 1'b1, 10'b1010101010, 10'b0101010101);
    check("R6 all forced value", pattern, 10'b1010101010);
    step("R6 all forced hold", 1'b1, 1'b0, '0, '0);
    // back to all random
    step("R9 release", 1'b1, 1'b1, '0, '0);
    for (int k = 0; k < 8; k++) step("R5 after release", 1'b1, 1'b0, '0, '0);
    // R8: idle holds
    for (int k = 0; k < 6; k++) step("R8 idle hold", 1'b0, 1'b0, '1, '1);
    step("R8 resume", 1'b1, 1'b0, '0, '0);
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic e, ld;
      logic [W-1:0] o, z;
      e  = ($urandom % 8) != 0;
      ld = ($urandom % 10) == 0;
      o  = W'($urandom) & W'($urandom);
      z  = W'($urandom) & W'($urandom);
      step("R5 random mix", e, ld, o, z);
    end
    // R1: reset mid-run restores seed behaviour
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    en = 1'b0; mask_load = 1'b0;
    m_a = '0; m_b = '0; m_one = '0; m_zero = '0; m_lfsr = 16'hACE1;
    check("R1 reset again", pattern, '0);
    for (int k = 0; k < 10; k++) step("R1 R7 reseeded", 1'b1, 1'b0, '0, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule